// File: doc/BRIEF.md
# Registered Single-Data-Rate Pad Buffer

This block sits between core logic and a group of tristate pads. It puts a register stage in each direction. Core output data and the output enable are captured on the output clock and then drive the pads. Pad levels are captured on a separate input clock and then handed to the core. The two clocks may come from unrelated domains.

A mode parameter builds the block as input-only, output-only or bidirectional. Only the logic that mode needs is generated. A per-bit polarity mask is applied on the way out and on the way back in, so the core always works in true polarity whatever the board wiring.

A second parameter adds a complement leg for each bit, which gives a pseudo-differential pair built from plain logic. The complement leg carries the inverse of the true leg under the same enable. The receive side reads only the true leg.

None of the datapath flops has a reset, a clock enable or an initial value. `rst_ni` only qualifies the built-in temporal checks and has no effect on the datapath.

Top module: `sdr_pad_buffer`

## Requirements
- R1: `DIR_MODE` takes the values PAD_IN (0), PAD_OUT (1) and PAD_BIDIR (2). In PAD_IN mode the pads are never driven, and `out_data_i` and `oe_i` have no effect.
- R2: In PAD_OUT mode no receive path exists, and `in_data_o` is held at all zeros.
- R3: In PAD_BIDIR mode, the value presented on `out_data_i` before a rising edge of `clk_out_i` appears on `pad_p_io` after that edge, and not before it.
- R4: In PAD_BIDIR mode `oe_i` is registered on `clk_out_i`. While the registered enable is 0, both pad legs are released to high impedance.
- R5: In PAD_OUT mode `oe_i` has no effect, and the pads are driven from the first output-clock edge onward.
- R6: Bit k of `INV_MASK` set to 1 inverts pad bit k relative to the core, both when driving and when capturing. A mask bit of 0 passes the bit unchanged.
- R7: With `PSEUDO_DIFF`=1, `pad_n_io` carries the bitwise inverse of `pad_p_io` under the same enable. With `PSEUDO_DIFF`=0, `pad_n_io` is never driven.
- R8: In PAD_IN and PAD_BIDIR modes, `in_data_o` takes `pad_p_io` XOR `INV_MASK` one rising edge of `clk_in_i` after the pad level is set. It changes only at `clk_in_i` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_out_i | input | 1 | Clock for the output data and enable registers |
| clk_in_i | input | 1 | Clock for the input capture registers |
| rst_ni | input | 1 | Active-low; qualifies the temporal checks only |
| out_data_i | input | WIDTH | Core data to drive, in true polarity |
| oe_i | input | 1 | Core output enable, used in PAD_BIDIR mode |
| in_data_o | output | WIDTH | Captured pad data, in true polarity |
| pad_p_io | inout | WIDTH | True pad leg |
| pad_n_io | inout | WIDTH | Complement pad leg, driven only when PSEUDO_DIFF=1 |

## Verification
The checks assume that at least one edge of each clock occurs while `rst_ni` is low, so every register has been loaded once before any `$past` term is read. They also assume that an outside driver on the pads is weaker than the block's own drivers. The bench holds reset over several cycles of both clocks and models the board only as a weak driver on every leg. The bench changes the core inputs on falling edges of the output clock and changes pad levels on falling edges of the input clock. The two clock periods are chosen so that these falling edges never coincide with a rising edge of the other clock, so no sample ever straddles an edge.

// File: rtl/sdr_pad_pkg.sv
package sdr_pad_pkg;
  typedef enum logic [1:0] {
    PAD_IN    = 2'd0,
    PAD_OUT   = 2'd1,
    PAD_BIDIR = 2'd2
  } pad_dir_e;
endpackage

// File: rtl/sdr_pad_out_stage.sv
module sdr_pad_out_stage #(
  parameter int unsigned          WIDTH     = 4,
  parameter logic [WIDTH-1:0]     INV_MASK  = '0,
  parameter bit                   HAS_OE    = 1'b1
) (
  input  logic             clk_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             oe_i,
  output logic [WIDTH-1:0] drv_p_o,
  output logic [WIDTH-1:0] drv_n_o,
  output logic             drv_en_o
);
  logic [WIDTH-1:0] data_q;

  // reset-less by intent
  always_ff @(posedge clk_i) data_q <= data_i;

  generate
    if (HAS_OE) begin : g_oe
      logic oe_q;
      always_ff @(posedge clk_i) oe_q <= oe_i;
      assign drv_en_o = oe_q;
    end else begin : g_no_oe
      logic unused_oe;
      assign unused_oe = oe_i;
      assign drv_en_o  = 1'b1;
    end
  endgenerate

  assign drv_p_o = data_q ^ INV_MASK;
  assign drv_n_o = ~drv_p_o;
endmodule

// File: rtl/sdr_pad_in_stage.sv
module sdr_pad_in_stage #(
  parameter int unsigned      WIDTH    = 4,
  parameter logic [WIDTH-1:0] INV_MASK = '0
) (
  input  logic             clk_i,
  input  logic [WIDTH-1:0] pad_i,
  output logic [WIDTH-1:0] data_o
);
  logic [WIDTH-1:0] cap_q;

  always_ff @(posedge clk_i) cap_q <= pad_i ^ INV_MASK;

  assign data_o = cap_q;
endmodule

// File: rtl/sdr_pad_buffer.sv
module sdr_pad_buffer
  import sdr_pad_pkg::*;
#(
  parameter int unsigned      WIDTH       = 4,
  parameter pad_dir_e         DIR_MODE    = PAD_BIDIR,
  parameter logic [WIDTH-1:0] INV_MASK    = '0,
  parameter bit               PSEUDO_DIFF = 1'b0
) (
  input  logic             clk_out_i,
  input  logic             clk_in_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] out_data_i,
  input  logic             oe_i,
  output logic [WIDTH-1:0] in_data_o,
  inout  wire  [WIDTH-1:0] pad_p_io,
  inout  wire  [WIDTH-1:0] pad_n_io
);
  localparam bit HAS_TX = (DIR_MODE != PAD_IN);
  localparam bit HAS_RX = (DIR_MODE != PAD_OUT);
  localparam bit HAS_OE = (DIR_MODE == PAD_BIDIR);

  generate
    if (HAS_TX) begin : g_tx
      logic [WIDTH-1:0] drv_p, drv_n;
      logic             drv_en;

      sdr_pad_out_stage #(
        .WIDTH    (WIDTH),
        .INV_MASK (INV_MASK),
        .HAS_OE   (HAS_OE)
      ) u_out (
        .clk_i    (clk_out_i),
        .data_i   (out_data_i),
        .oe_i     (oe_i),
        .drv_p_o  (drv_p),
        .drv_n_o  (drv_n),
        .drv_en_o (drv_en)
      );

      for (genvar k = 0; k < WIDTH; k++) begin : g_bit
        assign pad_p_io[k] = drv_en ? drv_p[k] : 1'bz;
        if (PSEUDO_DIFF) begin : g_n
          assign pad_n_io[k] = drv_en ? drv_n[k] : 1'bz;
        end else begin : g_no_n
          logic unused_n;
          assign unused_n    = drv_n[k];
          assign pad_n_io[k] = 1'bz;
        end
      end

      if (HAS_OE) begin : g_chk_bidir
        p_drive_lat_r3: assert property (@(posedge clk_out_i) disable iff (!rst_ni)
          $past(oe_i) |-> (pad_p_io == ($past(out_data_i) ^ INV_MASK)));
      end else begin : g_chk_out
        p_out_ignores_oe_r5: assert property (@(posedge clk_out_i) disable iff (!rst_ni)
          pad_p_io == ($past(out_data_i) ^ INV_MASK));
      end

      if (PSEUDO_DIFF) begin : g_chk_diff
        p_diff_complement_r7: assert property (@(posedge clk_out_i) disable iff (!rst_ni)
          (HAS_OE ? $past(oe_i) : 1'b1) |-> (pad_n_io == ~pad_p_io));
      end
    end else begin : g_no_tx
      logic unused_tx;
      assign unused_tx = ^{out_data_i, oe_i, clk_out_i};
      for (genvar k = 0; k < WIDTH; k++) begin : g_bit
        assign pad_p_io[k] = 1'bz;
        assign pad_n_io[k] = 1'bz;
      end
    end

    if (HAS_RX) begin : g_rx
      sdr_pad_in_stage #(
        .WIDTH    (WIDTH),
        .INV_MASK (INV_MASK)
      ) u_in (
        .clk_i  (clk_in_i),
        .pad_i  (pad_p_io),
        .data_o (in_data_o)
      );

      p_capture_r8: assert property (@(posedge clk_in_i) disable iff (!rst_ni)
        in_data_o == ($past(pad_p_io) ^ INV_MASK));
    end else begin : g_no_rx
      logic unused_rx;
      assign unused_rx = clk_in_i;
      assign in_data_o = '0;
    end
  endgenerate
endmodule

// File: tb/sdr_pad_buffer_tb.sv
`timescale 1ns/1ps
module sdr_pad_buffer_tb;
  import sdr_pad_pkg::*;

  localparam int W = 4;
  localparam logic [W-1:0] M_BI  = 4'b0101;
  localparam logic [W-1:0] M_OUT = 4'b0011;
  localparam logic [W-1:0] M_IN  = 4'b1000;

  logic clk_out = 1'b0, clk_in = 1'b0, rst_n = 1'b0;
  logic [W-1:0] out_data = '0, ext_val = '0;
  logic oe = 1'b0;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk_out = ~clk_out;
  always #3.5 clk_in  = ~clk_in;

  wire [W-1:0] bp, bn, op, on, ip, inn;
  logic [W-1:0] bi_in, o_in, i_in;

  // weak board drivers on every leg
  assign (weak0, weak1) bp  = ext_val;
  assign (weak0, weak1) bn  = ext_val;
  assign (weak0, weak1) op  = ext_val;
  assign (weak0, weak1) on  = ext_val;
  assign (weak0, weak1) ip  = ext_val;
  assign (weak0, weak1) inn = ext_val;

  sdr_pad_buffer #(.WIDTH(W), .DIR_MODE(PAD_BIDIR), .INV_MASK(M_BI), .PSEUDO_DIFF(1'b1)) u_dut (
    .clk_out_i(clk_out), .clk_in_i(clk_in), .rst_ni(rst_n), .out_data_i(out_data),
    .oe_i(oe), .in_data_o(bi_in), .pad_p_io(bp), .pad_n_io(bn));

  sdr_pad_buffer #(.WIDTH(W), .DIR_MODE(PAD_OUT), .INV_MASK(M_OUT), .PSEUDO_DIFF(1'b0)) u_dut_out (
    .clk_out_i(clk_out), .clk_in_i(clk_in), .rst_ni(rst_n), .out_data_i(out_data),
    .oe_i(oe), .in_data_o(o_in), .pad_p_io(op), .pad_n_io(on));

  sdr_pad_buffer #(.WIDTH(W), .DIR_MODE(PAD_IN), .INV_MASK(M_IN), .PSEUDO_DIFF(1'b1)) u_dut_in (
    .clk_out_i(clk_out), .clk_in_i(clk_in), .rst_ni(rst_n), .out_data_i(out_data),
    .oe_i(oe), .in_data_o(i_in), .pad_p_io(ip), .pad_n_io(inn));

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic t_reset_state();
    @(negedge clk_out);
    ext_val = 4'h9;
    #1;
    chk(bp == 4'h9, "R4 released after reset p", bp, 4'h9);
    chk(bn == 4'h9, "R4 released after reset n", bn, 4'h9);
    chk(op == (4'h0 ^ M_OUT), "R5 out mode driven with oe low", op, 4'h0 ^ M_OUT);
    chk(ip == 4'h9, "R1 input mode pads undriven", ip, 4'h9);
    chk(o_in == 4'h0, "R2 out mode rx zero", o_in, 4'h0);
  endtask

  task automatic t_bidir_drive();
    logic [W-1:0] prev;
    logic [W-1:0] pats [4] = '{4'hA, 4'h3, 4'hF, 4'h0};
    @(negedge clk_out);
    out_data = 4'h0;
    oe = 1'b1;
    @(negedge clk_out);
    prev = 4'h0 ^ M_BI;
    chk(bp == prev, "R3 first drive", bp, prev);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_out);
      out_data = pats[i];
      #1;
      chk(bp == prev, "R3 no early update", bp, prev);
      @(negedge clk_out);
      chk(bp == (pats[i] ^ M_BI), "R3 R6 drive with mask", bp, pats[i] ^ M_BI);
      chk(bn == ~(pats[i] ^ M_BI), "R7 complement leg", bn, ~(pats[i] ^ M_BI));
      prev = pats[i] ^ M_BI;
    end
  endtask

  task automatic t_bidir_release();
    logic [W-1:0] prev;
    @(negedge clk_out);
    out_data = 4'h6;
    @(negedge clk_out);
    prev = 4'h6 ^ M_BI;
    oe = 1'b0;
    ext_val = 4'hC;
    #1;
    chk(bp == prev, "R4 enable registered", bp, prev);
    @(negedge clk_out);
    chk(bp == 4'hC, "R4 p leg released", bp, 4'hC);
    chk(bn == 4'hC, "R4 n leg released", bn, 4'hC);
  endtask

  task automatic t_capture();
    logic [W-1:0] vals [3] = '{4'h3, 4'hE, 4'h7};
    logic [W-1:0] old_b, old_i;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_in);
      old_b = bi_in;
      old_i = i_in;
      ext_val = vals[i];
      #1;
      chk(bi_in == old_b, "R8 bidir no early capture", bi_in, old_b);
      chk(i_in == old_i, "R8 input no early capture", i_in, old_i);
      @(negedge clk_in);
      chk(bi_in == (vals[i] ^ M_BI), "R8 R6 bidir capture mask", bi_in, vals[i] ^ M_BI);
      chk(i_in == (vals[i] ^ M_IN), "R8 R6 input capture mask", i_in, vals[i] ^ M_IN);
    end
  endtask

  task automatic t_out_mode();
    @(negedge clk_out);
    oe = 1'b0;
    out_data = 4'h6;
    ext_val = 4'h2;
    @(negedge clk_out);
    chk(op == (4'h6 ^ M_OUT), "R5 R6 out mode drives", op, 4'h6 ^ M_OUT);
    chk(on == 4'h2, "R7 n leg undriven without pseudo diff", on, 4'h2);
    repeat (2) @(negedge clk_in);
    chk(o_in == 4'h0, "R2 out mode rx zero after activity", o_in, 4'h0);
  endtask

  task automatic t_in_mode();
    @(negedge clk_out);
    ext_val = 4'h5;
    out_data = 4'hF;
    oe = 1'b1;
    repeat (2) @(negedge clk_out);
    chk(ip == 4'h5, "R1 input mode ignores data and oe p", ip, 4'h5);
    chk(inn == 4'h5, "R1 input mode ignores data and oe n", inn, 4'h5);
    @(negedge clk_out);
    oe = 1'b0;
    @(negedge clk_out);
  endtask

  initial begin
    repeat (4) @(posedge clk_in);
    @(negedge clk_out);
    rst_n = 1'b1;
    t_reset_state();
    t_bidir_drive();
    t_bidir_release();
    t_capture();
    t_out_mode();
    t_in_mode();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=%h exp=%h", 1'b0, 1'b1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule